// File: doc/BRIEF.md
# Polynomial Signature Analyzer

This block folds a stream of circuit responses into a short signature by dividing the response polynomial by a fixed characteristic polynomial. The division runs in an internal-XOR shift register, and the remainder left in the register is the signature. Bits arrive highest-degree coefficient first. The register starts from a seed loaded by a synchronous clear.

Two compaction modes exist. The single-input mode takes one response bit per enabled clock. The multiple-input mode XORs a whole response word into every stage on each enabled clock. In that mode the final state is the superposition of the remainders of each lane's stream.

When the test ends, a done strobe compares the signature with an expected good-machine value. The verdict is valid from the next clock and holds until the next clear. A faulty response can alias to the good signature, so a pass does not prove the circuit is free of faults. Computing the golden value and generating the patterns belong to other blocks.

Top module: `sig_analyzer`

## Requirements
- R1: A cycle with `clear` high loads the register with `SEED` and drops `verdictValid` and `testPass`. This takes priority over `enable` and `done` in the same cycle.
- R2: In single-input mode (`modeMulti`=0), each enabled clock computes new stage 0 as old stage N-1 XOR `serialIn`. Each stage i>0 becomes old stage i-1 XOR (`POLY[i]` AND old stage N-1). `signature[i]` is the coefficient of x^i of the remainder.
- R3: The defaults are `POLY`=5'b01011 (1+x+x^3+x^5) and `SEED`=0. With those, the serial input 1,0,0,0,1,0,1,0 leaves `signature`=5'b01101 (1+x^2+x^3).
- R4: In multiple-input mode (`modeMulti`=1), each enabled clock applies the R2 shift and also XORs `parallelIn[i]` into new stage i. `serialIn` is ignored in this mode.
- R5: With a zero seed, the multiple-input signature of word stream A XOR B equals the XOR of the signatures of A and B. A stream that uses only lane 0 gives the same signature as the serial run of that lane.
- R6: While `enable` and `done` are low and `clear` is low, `signature` holds.
- R7: `done` raises `verdictValid` one clock later. `testPass` then reports whether the signature after that edge equals the `expectedSig` sampled in the done cycle. A shift by `enable` in the same cycle is included in that signature.
- R8: Once `verdictValid` is high, `signature`, `verdictValid` and `testPass` hold until the next clear. During that time `enable`, `done` and `expectedSig` have no effect.
- R9: Flipping any single response bit in a stream changes the final signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clear | input | 1 | Synchronous clear to seed |
| enable | input | 1 | Compact one response this cycle |
| modeMulti | input | 1 | 0 = single-input, 1 = multiple-input |
| serialIn | input | 1 | Serial response bit |
| parallelIn | input | N | Parallel response word |
| expectedSig | input | N | Good-machine signature, sampled with done |
| done | input | 1 | End-of-test strobe |
| signature | output | N | Current register contents (remainder) |
| verdictValid | output | 1 | Verdict available |
| testPass | output | 1 | 1 when the signature matched |

## Verification
The last response shift and the done strobe can land in the same cycle. The verdict must then be judged on the remainder that includes that final bit. The bench provokes this by raising `enable` with the last bit together with `done`. It gives an expected value equal to the fully updated model remainder, and then one differing in a single bit, so a compare against the stale register is visible. The clear/done/enable collision is also driven, and the seed with no verdict is expected.

// File: rtl/sa_pkg.sv
package sa_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;     // force seed
    logic shift;    // compact one response
    logic multi;    // use the parallel word
    logic capture;  // latch the verdict this edge
  } saCtrl_t;
endpackage

// File: rtl/sa_datapath.sv
module sa_datapath
  import sa_pkg::*;
#(
  parameter int N = 5,
  parameter logic [N-1:0] POLY = 5'b01011,
  parameter logic [N-1:0] SEED = '0
) (
  input  logic         clk,
  input  saCtrl_t      ctrl,
  input  logic         serialIn,
  input  logic [N-1:0] parallelIn,
  input  logic [N-1:0] expectedSig,
  output logic [N-1:0] signature,
  output logic         matchNext
);
  // constant term of the divisor is always present
  localparam logic [N-1:0] TAPS = POLY | {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] sigQ;
  logic [N-1:0] inject;
  logic [N-1:0] divided;
  logic [N-1:0] sigNext;
  logic         feedBack;

  assign feedBack = sigQ[N-1];
  assign inject   = ctrl.multi ? parallelIn : {{(N-1){1'b0}}, serialIn};

  // stage 0 takes feedback directly, others shift through XOR taps
  assign divided[0] = feedBack ^ inject[0];
  for (genvar i = 1; i < N; i++) begin : g_stage
    assign divided[i] = sigQ[i-1] ^ (TAPS[i] & feedBack) ^ inject[i];
  end

  always_comb begin
    if (ctrl.load)       sigNext = SEED;
    else if (ctrl.shift) sigNext = divided;
    else                 sigNext = sigQ;
  end

  always_ff @(posedge clk) sigQ <= sigNext;

  assign signature = sigQ;
  assign matchNext = (sigNext == expectedSig);
endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl
  import sa_pkg::*;
(
  input  logic    clk,
  input  logic    clear,
  input  logic    enable,
  input  logic    modeMulti,
  input  logic    done,
  input  logic    matchNext,
  output saCtrl_t ctrl,
  output logic    verdictValid,
  output logic    testPass
);
  logic validQ;
  logic passQ;

  always_comb begin
    ctrl.load    = clear;
    ctrl.shift   = enable & ~clear & ~validQ;
    ctrl.multi   = modeMulti;
    ctrl.capture = done & ~clear & ~validQ;
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      validQ <= 1'b0;
      passQ  <= 1'b0;
    end else if (ctrl.capture) begin
      validQ <= 1'b1;
      passQ  <= matchNext;
    end
  end

  assign verdictValid = validQ;
  assign testPass     = passQ;
endmodule

// File: rtl/sig_analyzer.sv
module sig_analyzer
  import sa_pkg::*;
#(
  parameter int N = 5,
  parameter logic [N-1:0] POLY = 5'b01011,
  parameter logic [N-1:0] SEED = '0
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         enable,
  input  logic         modeMulti,
  input  logic         serialIn,
  input  logic [N-1:0] parallelIn,
  input  logic [N-1:0] expectedSig,
  input  logic         done,
  output logic [N-1:0] signature,
  output logic         verdictValid,
  output logic         testPass
);
  saCtrl_t ctrl;
  logic    matchNext;

  sa_ctrl u_ctrl (
    .clk(clk), .clear(clear), .enable(enable), .modeMulti(modeMulti),
    .done(done), .matchNext(matchNext), .ctrl(ctrl),
    .verdictValid(verdictValid), .testPass(testPass)
  );

  sa_datapath #(.N(N), .POLY(POLY), .SEED(SEED)) u_dp (
    .clk(clk), .ctrl(ctrl), .serialIn(serialIn), .parallelIn(parallelIn),
    .expectedSig(expectedSig), .signature(signature), .matchNext(matchNext)
  );
endmodule

// File: rtl/sig_analyzer_chk.sv
module sig_analyzer_chk #(
  parameter int N = 5,
  parameter logic [N-1:0] SEED = '0
) (
  input logic         clk,
  input logic         clear,
  input logic         enable,
  input logic         modeMulti,
  input logic         serialIn,
  input logic [N-1:0] parallelIn,
  input logic         done,
  input logic [N-1:0] signature,
  input logic         verdictValid,
  input logic         testPass
);
  logic seenClear = 1'b0;
  always_ff @(posedge clk) if (clear) seenClear <= 1'b1;

  assert_clear_seed_R1: assert property (@(posedge clk) disable iff (!seenClear)
    clear |=> (signature == SEED) && !verdictValid && !testPass);

  assert_serial_stage0_R2: assert property (@(posedge clk) disable iff (!seenClear || clear)
    enable && !modeMulti && !verdictValid |=>
      signature[0] == ($past(signature[N-1]) ^ $past(serialIn)));

  assert_multi_stage0_R4: assert property (@(posedge clk) disable iff (!seenClear || clear)
    enable && modeMulti && !verdictValid |=>
      signature[0] == ($past(signature[N-1]) ^ $past(parallelIn[0])));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!seenClear || clear)
    !enable && !done |=> $stable(signature));

  assert_done_valid_R7: assert property (@(posedge clk) disable iff (!seenClear || clear)
    done |=> verdictValid);

  assert_no_early_valid_R7: assert property (@(posedge clk) disable iff (!seenClear || clear)
    !verdictValid && !done |=> !verdictValid);

  assert_verdict_hold_R8: assert property (@(posedge clk) disable iff (!seenClear || clear)
    verdictValid |=> verdictValid && $stable(signature) && $stable(testPass));
endmodule

bind sig_analyzer sig_analyzer_chk #(.N(N), .SEED(SEED)) u_chk (
  .clk(clk), .clear(clear), .enable(enable), .modeMulti(modeMulti),
  .serialIn(serialIn), .parallelIn(parallelIn), .done(done),
  .signature(signature), .verdictValid(verdictValid), .testPass(testPass)
);

// File: tb/sig_analyzer_tb.sv
module sig_analyzer_tb;
  localparam int N = 5;
  localparam logic [N-1:0] POLY = 5'b01011;
  localparam int MAXLEN = 32;

  logic         clk = 1'b0;
  logic         clear, enable, modeMulti, serialIn, done;
  logic [N-1:0] parallelIn, expectedSig;
  logic [N-1:0] signature;
  logic         verdictValid, testPass;

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;

  logic         seqS [MAXLEN];
  logic [N-1:0] seqP [MAXLEN];

  always #4 clk = ~clk;

  sig_analyzer #(.N(N), .POLY(POLY), .SEED('0)) u_dut (
    .clk(clk), .clear(clear), .enable(enable), .modeMulti(modeMulti),
    .serialIn(serialIn), .parallelIn(parallelIn), .expectedSig(expectedSig),
    .done(done), .signature(signature), .verdictValid(verdictValid),
    .testPass(testPass)
  );

  // division step as the requirements define it
  function automatic logic [N-1:0] stepM(logic [N-1:0] s, logic multi,
                                         logic si, logic [N-1:0] pi);
    logic [N-1:0] r;
    r = {s[N-2:0], 1'b0};
    if (s[N-1]) r = r ^ (POLY | 5'b00001);
    r = r ^ (multi ? pi : {{(N-1){1'b0}}, si});
    return r;
  endfunction

  function automatic logic [N-1:0] modelRun(logic multi, int len);
    logic [N-1:0] s = '0;
    for (int i = 0; i < len; i++) s = stepM(s, multi, seqS[i], seqP[i]);
    return s;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic cyc(input logic cl, input logic en, input logic md, input logic si,
                     input logic [N-1:0] pi, input logic dn);
    clear = cl; enable = en; modeMulti = md; serialIn = si;
    parallelIn = pi; done = dn;
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0, 0, modeMulti, 0, '0, 0);
  endtask

  task automatic runSeq(input logic multi, input int len);
    cyc(1, 0, multi, 0, '0, 0);
    for (int i = 0; i < len; i++) cyc(0, 1, multi, seqS[i], seqP[i], 0);
    clear = 0; enable = 0; done = 0;
  endtask

  task automatic randSeq(input int len);
    for (int i = 0; i < len; i++) begin
      seqS[i] = 1'($urandom);
      seqP[i] = N'($urandom);
    end
  endtask

  initial begin
    logic [N-1:0] sa, sb, sx, ref0;
    logic [N-1:0] saveP [MAXLEN];
    logic         saveS [MAXLEN];
    void'($urandom(32'd1234));
    clear = 1; enable = 0; modeMulti = 0; serialIn = 0; done = 0;
    parallelIn = '0; expectedSig = '0;
    @(negedge clk);
    cyc(1, 0, 0, 0, '0, 0);
    check(signature == 5'b0 && !verdictValid && !testPass, "R1 reset state",
          {signature, verdictValid, testPass}, 0);

    // R3 directed division example
    begin
      logic [7:0] bits = 8'b1000_1010;
      for (int i = 0; i < 8; i++) begin seqS[i] = bits[7-i]; seqP[i] = 5'h1f; end
    end
    runSeq(0, 8);
    check(signature == 5'b01101, "R3 divisor example", signature, 5'b01101);

    // R2 random serial runs
    for (int t = 0; t < 4; t++) begin
      randSeq(MAXLEN);
      runSeq(0, 10 + t * 5);
      check(signature == modelRun(0, 10 + t * 5), "R2 serial random",
            signature, modelRun(0, 10 + t * 5));
    end

    // R4 random multi-input runs, serialIn toggling randomly
    for (int t = 0; t < 4; t++) begin
      randSeq(MAXLEN);
      runSeq(1, 12 + t * 4);
      check(signature == modelRun(1, 12 + t * 4), "R4 multi random",
            signature, modelRun(1, 12 + t * 4));
    end

    // R5 superposition
    randSeq(MAXLEN);
    for (int i = 0; i < MAXLEN; i++) begin saveP[i] = seqP[i]; saveS[i] = seqS[i]; end
    runSeq(1, 20); sa = signature;
    randSeq(MAXLEN);
    runSeq(1, 20); sb = signature;
    for (int i = 0; i < MAXLEN; i++) seqP[i] = seqP[i] ^ saveP[i];
    runSeq(1, 20); sx = signature;
    check(sx == (sa ^ sb), "R5 xor superposition", sx, sa ^ sb);
    for (int i = 0; i < MAXLEN; i++) begin
      seqS[i] = saveS[i]; seqP[i] = {{(N-1){1'b0}}, saveS[i]};
    end
    runSeq(0, 20); ref0 = signature;
    runSeq(1, 20);
    check(signature == ref0, "R5 lane0 equals serial", signature, ref0);

    // R6 idle hold
    sa = signature;
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1'($urandom), N'($urandom), 0);
    check(signature == sa && !verdictValid, "R6 idle hold", signature, sa);

    // R7 done in the same cycle as the last shift, matching golden
    randSeq(MAXLEN);
    runSeq(0, 15);
    sa = modelRun(0, 16);
    expectedSig = sa;
    cyc(0, 1, 0, seqS[15], '0, 1);
    check(verdictValid && testPass && signature == sa, "R7 done with last shift pass",
          {verdictValid, testPass, signature}, {2'b11, sa});

    // R8 frozen after verdict
    expectedSig = ~sa;
    for (int i = 0; i < 4; i++) cyc(0, 1, 1'($urandom), 1, N'($urandom), 1);
    check(verdictValid && testPass && signature == sa, "R8 verdict hold",
          {verdictValid, testPass, signature}, {2'b11, sa});

    // R7 mismatch by a single bit
    runSeq(1, 15);
    sa = modelRun(1, 16);
    expectedSig = sa ^ 5'b00100;
    cyc(0, 1, 1, 0, seqP[15], 1);
    check(verdictValid && !testPass, "R7 single-bit mismatch fails",
          {verdictValid, testPass}, 2'b10);

    // R7 done alone, random golden check
    runSeq(0, 9);
    expectedSig = modelRun(0, 9);
    cyc(0, 0, 0, 1, '0, 1);
    expectedSig = '0;
    check(verdictValid && testPass, "R7 done without shift",
          {verdictValid, testPass}, 2'b11);

    // R1 clear beats enable and done
    cyc(1, 1, 0, 1, '1, 1);
    check(signature == 5'b0 && !verdictValid && !testPass, "R1 clear priority",
          {signature, verdictValid, testPass}, 0);
    idle();
    check(!verdictValid, "R1 no verdict after clear+done", verdictValid, 0);

    // R9 one flipped response bit changes the signature
    for (int t = 0; t < 4; t++) begin
      int pos = int'($urandom % 24);
      randSeq(MAXLEN);
      runSeq(0, 24); sa = signature;
      seqS[pos] = ~seqS[pos];
      runSeq(0, 24); sb = signature;
      check(sa != sb, "R9 flipped bit detected", sb, sa);
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule